// File: doc/BRIEF.md
# Seed-and-Neighbour Cluster Finder

This block takes one frame of pixel amplitudes, with pedestals already removed, in raster order: row 0 first, and within each row column 0 first. It reports every charge cluster in the frame as one record. A pixel becomes the seed of a cluster when it is above a high cut and is the largest value in its 3x3 neighbourhood. The pixels around the seed that are above a lower cut join the cluster. Each record gives the seed row and column, the summed amplitude of the seed and its accepted neighbours, and how many pixels were summed.

Both cuts are given as one noise figure (one sigma, in amplitude units) and two small integer multipliers. The seed cut is therefore sigma times the seed multiplier, and the neighbour cut is sigma times the neighbour multiplier. Seed multipliers of 5 to 7 are the useful range, and 2 suits the neighbour cut.

Two row buffers and a 3x3 register window give the block its view of the frame. The block extends the frame with one zero column on the right and one zero row at the bottom, and inserts those padding steps itself. The input sees these steps as short stalls. Records leave through a valid/ready port. When a record is waiting and the receiver is not ready, the block stops accepting pixels.

Top module: `clu_finder`

## Requirements
- R1: After reset, `clu_valid` is 0 and `pix_ready` is 1.
- R2: A pixel is reported as a seed only when its amplitude is strictly greater than `noise_sigma*seed_k`. A pixel exactly equal to that product is not a seed.
- R3: A record's `clu_sum` is the seed amplitude plus every pixel of the 3x3 window around the seed whose amplitude is strictly greater than `noise_sigma*nbr_k`. `clu_npix` is 1 plus the number of those pixels. Pixels outside the window never contribute.
- R4: When neighbours share the seed's amplitude, the pixel with the lower column wins, and in the same column the pixel with the lower row wins. A flat pair therefore gives exactly one record.
- R5: A pixel above the seed cut is not reported when a larger pixel lies in its 3x3 window.
- R6: Positions outside the frame count as amplitude 0. Seeds on any edge or corner are reported, and no window wraps from the end of one row to the start of the next.
- R7: For a seed at row r, column c with r < ROWS-1 and c < COLS-1, the record is valid in the cycle after the clock edge that accepts the pixel at row r+1, column c+1.
- R8: While `clu_valid` is 1 and `clu_ready` is 0, the record fields hold their values and `pix_ready` is 0. No record is lost.
- R9: Records leave in the raster order of their seed positions, one record per seed. Seeds in the last row and last column are flushed by the padding steps without further input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel amplitude offered |
| pix_ready | output | 1 | Pixel accepted on this edge when pix_valid is 1 |
| pix_amp | input | AW | Pedestal-subtracted amplitude, unsigned |
| noise_sigma | input | AW | Noise level in amplitude units |
| seed_k | input | KW | Seed cut multiplier |
| nbr_k | input | KW | Neighbour cut multiplier |
| clu_valid | output | 1 | Cluster record present |
| clu_ready | input | 1 | Receiver takes the record on this edge |
| clu_row | output | YW | Seed row |
| clu_col | output | XW | Seed column |
| clu_sum | output | AW+4 | Summed amplitude |
| clu_npix | output | 4 | Pixels in the sum, 1 to 9 |

## Verification
The block decides a seed on the same edge that moves the window past it. For an interior seed this is the edge that takes the pixel diagonally below and to the right of the seed, and the record is visible one cycle later. The bench counts accepted pixels at each falling edge, stores that count with every record it takes, and compares the count against (r+1)*COLS+c+2 for interior seeds. Seeds in the last row or column are emitted during the padding steps that follow the frame, so the bench waits a fixed drain period before comparing the record list. All signals are sampled one time unit after the falling edge, once the inputs driven at that edge have settled.

// File: rtl/clu_finder.sv
module clu_finder #(
  parameter int AW   = 10,
  parameter int KW   = 3,
  parameter int COLS = 16,
  parameter int ROWS = 8,
  localparam int XW  = $clog2(COLS + 1),
  localparam int YW  = $clog2(ROWS + 1),
  localparam int SW  = AW + 4,
  localparam int TW  = AW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [AW-1:0] pix_amp,
  input  logic [AW-1:0] noise_sigma,
  input  logic [KW-1:0] seed_k,
  input  logic [KW-1:0] nbr_k,
  output logic          clu_valid,
  input  logic          clu_ready,
  output logic [YW-1:0] clu_row,
  output logic [XW-1:0] clu_col,
  output logic [SW-1:0] clu_sum,
  output logic [3:0]    clu_npix
);

  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [AW-1:0] lb1 [COLS+1];
  logic [AW-1:0] lb2 [COLS+1];
  logic [AW-1:0] w  [3][3];
  logic [AW-1:0] nw [3][3];
  logic          is_max, hit;
  logic [SW-1:0] sum;
  logic [3:0]    cnt;

  wire           pad      = (x == XW'(COLS)) || (y == YW'(ROWS));
  wire           out_free = !clu_valid || clu_ready;
  wire           step     = pad ? out_free : (pix_valid && out_free);
  wire [AW-1:0]  cur      = pad ? '0 : pix_amp;
  wire [AW-1:0]  top      = (y > YW'(1)) ? lb2[x] : '0;
  wire [AW-1:0]  mid      = (y != '0) ? lb1[x] : '0;
  wire [TW-1:0]  seed_thr = TW'(noise_sigma) * TW'(seed_k);
  wire [TW-1:0]  nbr_thr  = TW'(noise_sigma) * TW'(nbr_k);

  assign pix_ready = !pad && out_free;

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      nw[r][0] = (x == '0) ? '0 : w[r][1];
      nw[r][1] = (x == '0) ? '0 : w[r][2];
    end
    nw[0][2] = top;
    nw[1][2] = mid;
    nw[2][2] = cur;
  end

  always_comb begin
    is_max = 1'b1;
    sum    = SW'(nw[1][1]);
    cnt    = 4'd1;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        if (!(r == 1 && c == 1)) begin
          if (c < 1 || (c == 1 && r < 1)) begin
            if (nw[r][c] >= nw[1][1]) is_max = 1'b0;
          end else begin
            if (nw[r][c] > nw[1][1]) is_max = 1'b0;
          end
          if (TW'(nw[r][c]) > nbr_thr) begin
            sum = sum + SW'(nw[r][c]);
            cnt = cnt + 4'd1;
          end
        end
      end
    end
  end

  assign hit = (y != '0) && (x != '0) && is_max && (TW'(nw[1][1]) > seed_thr);

  always_ff @(posedge clk) begin
    if (step) begin
      lb2[x] <= lb1[x];
      lb1[x] <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x         <= '0;
      y         <= '0;
      w         <= '{default: '{default: '0}};
      clu_valid <= 1'b0;
      clu_row   <= '0;
      clu_col   <= '0;
      clu_sum   <= '0;
      clu_npix  <= '0;
    end else begin
      if (step) begin
        w <= nw;
        if (x == XW'(COLS)) begin
          x <= '0;
          y <= (y == YW'(ROWS)) ? '0 : y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
      end
      if (step && hit) begin
        clu_valid <= 1'b1;
        clu_row   <= y - 1'b1;
        clu_col   <= x - 1'b1;
        clu_sum   <= sum;
        clu_npix  <= cnt;
      end else if (clu_ready) begin
        clu_valid <= 1'b0;
      end
    end
  end

endmodule

module clu_finder_chk #(
  parameter int COLS = 16,
  parameter int ROWS = 8,
  parameter int XW   = 5,
  parameter int YW   = 4,
  parameter int SW   = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ready,
  input logic          clu_valid,
  input logic          clu_ready,
  input logic [YW-1:0] clu_row,
  input logic [XW-1:0] clu_col,
  input logic [SW-1:0] clu_sum,
  input logic [3:0]    clu_npix
);

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !clu_valid && pix_ready);

  p_npix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid |-> clu_npix >= 4'd1 && clu_npix <= 4'd9);

  p_coord_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid |-> clu_row < YW'(ROWS) && clu_col < XW'(COLS));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid && !clu_ready |=> clu_valid && $stable(clu_row) && $stable(clu_col)
      && $stable(clu_sum) && $stable(clu_npix));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid && !clu_ready |-> !pix_ready);

endmodule

bind clu_finder clu_finder_chk #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW), .SW(SW)) u_chk (.*);

// File: tb/clu_finder_tb.sv
module clu_finder_tb;
  localparam int AW = 10, KW = 3, COLS = 8, ROWS = 6;
  localparam int XW = $clog2(COLS + 1), YW = $clog2(ROWS + 1), SW = AW + 4;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, clu_ready = 1;
  logic [AW-1:0] pix_amp = '0, noise_sigma = '0;
  logic [KW-1:0] seed_k = '0, nbr_k = '0;
  logic pix_ready, clu_valid;
  logic [YW-1:0] clu_row;
  logic [XW-1:0] clu_col;
  logic [SW-1:0] clu_sum;
  logic [3:0] clu_npix;

  int checks = 0, errors = 0, cyc = 0, acc_n = 0, n_rec = 0;
  bit stall_on = 0;
  int img [ROWS][COLS];
  int rec_row [32], rec_col [32], rec_sum [32], rec_n [32], rec_stamp [32];

  clu_finder #(.AW(AW), .KW(KW), .COLS(COLS), .ROWS(ROWS)) u_dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    clu_ready = stall_on ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && clu_valid && clu_ready && n_rec < 32) begin
      rec_row[n_rec] = int'(clu_row);
      rec_col[n_rec] = int'(clu_col);
      rec_sum[n_rec] = int'(clu_sum);
      rec_n[n_rec] = int'(clu_npix);
      rec_stamp[n_rec] = acc_n;
      n_rec++;
    end
    if (rst_n && pix_valid && pix_ready) acc_n++;
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_rec(input string tag, input int i, input int r, input int c,
                         input int s, input int n);
    chk({tag, " row"}, rec_row[i], r);
    chk({tag, " col"}, rec_col[i], c);
    chk({tag, " sum"}, rec_sum[i], s);
    chk({tag, " npix"}, rec_n[i], n);
  endtask

  task automatic setup(input int sig, input int sk, input int nk);
    noise_sigma = AW'(sig);
    seed_k = KW'(sk);
    nbr_k = KW'(nk);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = 0;
    for (int i = 0; i < 32; i++) begin
      rec_row[i] = -1; rec_col[i] = -1; rec_sum[i] = -1; rec_n[i] = -1; rec_stamp[i] = -1;
    end
    n_rec = 0;
    acc_n = 0;
  endtask

  task automatic run_frame;
    @(negedge clk);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        pix_valid = 1'b1;
        pix_amp = AW'(img[r][c]);
        #1;
        while (!pix_ready) begin
          @(negedge clk);
          #1;
        end
        @(negedge clk);
      end
    end
    pix_valid = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    chk("R1 clu_valid after reset", int'(clu_valid), 0);
    chk("R1 pix_ready after reset", int'(pix_ready), 1);
  endtask

  task automatic t_single;
    setup(10, 5, 2);
    img[2][3] = 60;
    run_frame();
    chk("R2 single count", n_rec, 1);
    chk_rec("R2 single", 0, 2, 3, 60, 1);
    chk("R7 single latency stamp", rec_stamp[0], 3 * COLS + 3 + 2);
  endtask

  task automatic t_threshold;
    setup(8, 7, 2);
    img[1][1] = 56;
    img[3][4] = 57;
    run_frame();
    chk("R2 equal-to-cut not seeded, count", n_rec, 1);
    chk_rec("R2 above cut", 0, 3, 4, 57, 1);
  endtask

  task automatic t_neigh;
    setup(10, 5, 2);
    img[2][3] = 100;
    img[1][2] = 21;
    img[1][3] = 20;
    img[2][4] = 30;
    img[3][3] = 25;
    img[3][4] = 5;
    img[2][5] = 40;
    run_frame();
    chk("R3 neighbour count", n_rec, 1);
    chk_rec("R3 neighbour sum", 0, 2, 3, 176, 4);
    chk("R7 neighbour latency stamp", rec_stamp[0], 3 * COLS + 3 + 2);
  endtask

  task automatic t_tie;
    setup(10, 5, 2);
    img[2][3] = 80;
    img[2][4] = 80;
    img[3][6] = 70;
    img[4][6] = 70;
    run_frame();
    chk("R4 tie count", n_rec, 2);
    chk_rec("R4 column tie", 0, 2, 3, 160, 2);
    chk_rec("R4 row tie", 1, 3, 6, 140, 2);
  endtask

  task automatic t_suppress;
    setup(10, 5, 2);
    img[3][3] = 60;
    img[3][4] = 90;
    run_frame();
    chk("R5 suppression count", n_rec, 1);
    chk_rec("R5 larger neighbour wins", 0, 3, 4, 150, 2);
  endtask

  task automatic t_edges;
    setup(10, 5, 2);
    img[0][0] = 60;
    img[1][0] = 45;
    img[0][7] = 70;
    img[1][6] = 30;
    img[5][0] = 55;
    img[5][7] = 99;
    img[4][7] = 25;
    img[5][6] = 21;
    run_frame();
    chk("R6 edge count", n_rec, 4);
    chk_rec("R6 top-left", 0, 0, 0, 105, 2);
    chk_rec("R6 top-right no wrap", 1, 0, 7, 100, 2);
    chk_rec("R6 bottom-left", 2, 5, 0, 55, 1);
    chk_rec("R9 bottom-right flushed", 3, 5, 7, 145, 3);
  endtask

  task automatic t_stall;
    setup(10, 5, 2);
    for (int k = 0; k < 4; k++) begin
      img[1][2 * k + 1] = 60 + k;
      img[3][2 * k + 1] = 64 + k;
    end
    stall_on = 1;
    run_frame();
    stall_on = 0;
    chk("R8 stalled record count", n_rec, 8);
    for (int k = 0; k < 4; k++) begin
      chk_rec("R8 R9 row1 order", k, 1, 2 * k + 1, 60 + k, 1);
      chk_rec("R8 R9 row3 order", 4 + k, 3, 2 * k + 1, 64 + k, 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_threshold();
    t_neigh();
    t_tie();
    t_suppress();
    t_stall();
    t_edges();
    summary();
  end
endmodule